// File: doc/BRIEF.md
# Serial Converter Command and Result Port

This block is the device-side digital front end of a serial analog-to-digital converter. The host frames each transfer by pulling chip select low and toggling a serial clock. On every frame the port takes in an 8-bit command word, most significant bit first, on the rising clock edges. On the falling edges it sends back the result of the previous conversion. The result is shaped by three settings: word length (8, 12 or 16 bits), bit order (MSB or LSB first) and number format (unsigned or two's-complement style).

After the last falling edge of a frame, counted against the active word length, the port raises a one-cycle conversion-start pulse and presents the requested channel code with it. The analog converter sits outside this block. It returns its 12-bit code on `resultIn` with a `resultValid` strobe, and the port holds that code until the next frame sends it out. All serial signals are sampled on the fast system clock, so `sclk` is treated as a slow, already synchronous input.

The command word splits into four fields. The code is bits [7:4]: 0 to 10 select analog inputs, 11 to 13 select reference test voltages, 14 requests power-down and 15 is reserved. Bits [3:2] set the word length, bit 1 sets the bit order and bit 0 sets the number format.

Top module: `adc_serial_port`

## Requirements
- R1: A completed frame whose command code is 0 to 13 produces exactly one `convStart` pulse, one system clock long, with `convChan` equal to that code.
- R2: Length bits [3:2] decode as follows: 00 and 10 give 12 bits, 01 gives 8 bits and 11 gives 16 bits. The conversion-start pulse follows the falling edge whose count equals the active length.
- R3: In 16-bit mode the 12-bit result is followed by four zero bits in the low positions. In 8-bit mode only result bits [11:4] are sent.
- R4: A length written in a frame applies to that same frame from its sixth rising edge on. Edges beyond the active length produce no further pulse and drive `sdo` low.
- R5: Bit 1 of the command selects the bit order (0 = MSB first, 1 = LSB first). It applies only from the next frame. When the length changes while LSB-first order is active, only the frame carrying the change may send a corrupted word.
- R6: Bit 0 of the command selects the number format of the conversion that the command starts: 0 sends the code unchanged, 1 sends it with bit 11 inverted.
- R7: Code 14 gives no conversion-start pulse and sets `powerDown`. A later completed frame with a code of 0 to 13 clears it.
- R8: Code 15 gives no pulse, leaves `powerDown` unchanged and leaves length, order and format unchanged.
- R9: While chip select is high, `sdoEn` is low and the edge counters are cleared. A frame that ends before its active length triggers nothing and commits no bit order.
- R10: After reset the port is in 12-bit, MSB-first, unsigned mode with a zero result, `powerDown` low and `sdoEn` low.
- R11: Within a frame, `sdo` changes only at frame start, after a falling serial edge, when the length is reloaded or when a new result is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial command input, sampled on rising `sclk` |
| sdo | output | 1 | Serial result output, updated after falling `sclk` |
| sdoEn | output | 1 | Output enable for an external tristate driver |
| resultIn | input | 12 | Code returned by the converter |
| resultValid | input | 1 | One-cycle strobe that captures `resultIn` |
| convStart | output | 1 | One-cycle conversion request |
| convChan | output | 4 | Channel code that goes with `convStart` |
| powerDown | output | 1 | Power-down status |

## Verification
The command sequence walks through all three lengths, both bit orders and both formats. Because each result carries a distinct bit pattern, the tests can tell reversed order, a lost pad nibble and truncation apart. An LSB-first frame that moves from 12 to 16 bits has its output left unchecked, and the frame after it must come out clean. This separates the single permitted corruption from a lasting misalignment.

A reserved command carries an 8-bit length. Had that length been taken up, result bit 3 would land in an output slot where a 12-bit frame sends a one, so the test detects it. A frame clocked past its length shows whether the trigger fires once and at the right edge. A frame aborted after five edges shows that neither the length nor the order was committed.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  localparam int RES_W     = 12;
  localparam int PAD_W     = 4;
  localparam int CMD_W     = 8;
  localparam int CODE_W    = 4;
  localparam int LEN_RISE  = 6;
  localparam int LEN_LONG  = RES_W + PAD_W;
  localparam int LEN_SHORT = RES_W - PAD_W;
  localparam int CNT_W     = $clog2(LEN_LONG + 1);
  localparam int IDX_W     = $clog2(LEN_LONG);
  localparam logic [CODE_W-1:0] LAST_CHAN = CODE_W'(13);
  localparam logic [CODE_W-1:0] PD_CODE   = CODE_W'(14);
  localparam logic [CODE_W-1:0] RSV_CODE  = CODE_W'(15);

  typedef struct packed {
    logic             fallStb;
    logic             lenLoad;
    logic [CNT_W-1:0] bitIdx;
    logic [1:0]       lenCode;
    logic             lsbFirst;
    logic             outEn;
    logic             fmtBit;
  } portCtlT;

  function automatic logic [CNT_W-1:0] lenOf(input logic [1:0] code);
    case (code)
      2'b11:   return CNT_W'(LEN_LONG);
      2'b01:   return CNT_W'(LEN_SHORT);
      default: return CNT_W'(RES_W);
    endcase
  endfunction
endpackage

// File: rtl/spd_ctrl.sv
module spd_ctrl
  import adc_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  output portCtlT           ctl,
  output logic              convStart,
  output logic [CODE_W-1:0] convChan,
  output logic              powerDown
);
  logic             sclkQ, riseStb, fallStb, lenLoad, lastFall;
  logic             doneFlag, lsbFirst, lsbPend, fmtPend, outEn;
  logic [CNT_W-1:0] riseCnt, fallCnt, activeLen;
  logic [CMD_W-1:0] cmdSh;
  logic [1:0]       lenCode;
  logic [CODE_W-1:0] cmdCode;

  assign riseStb   = !csN && sclk && !sclkQ;
  assign fallStb   = !csN && !sclk && sclkQ;
  assign activeLen = lenOf(lenCode);
  assign cmdCode   = cmdSh[CMD_W-1 -: CODE_W];
  // sixth rising edge: code field already shifted in, length LSB on sdi
  assign lenLoad   = riseStb && (riseCnt == CNT_W'(LEN_RISE - 1)) &&
                     (cmdSh[LEN_RISE-2 -: CODE_W] != RSV_CODE);
  assign lastFall  = fallStb && ((fallCnt + CNT_W'(1)) == activeLen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ <= 1'b0; outEn <= 1'b0; convStart <= 1'b0; convChan <= '0;
      powerDown <= 1'b0; riseCnt <= '0; fallCnt <= '0; cmdSh <= '0;
      lenCode <= 2'b00; lsbFirst <= 1'b0; lsbPend <= 1'b0;
      fmtPend <= 1'b0; doneFlag <= 1'b0;
    end else begin
      sclkQ     <= sclk;
      outEn     <= !csN;
      convStart <= 1'b0;
      if (csN) begin
        riseCnt <= '0;
        fallCnt <= '0;
        if (doneFlag) begin
          lsbFirst <= lsbPend;
          doneFlag <= 1'b0;
        end
      end else begin
        if (riseStb && riseCnt < CNT_W'(CMD_W)) begin
          cmdSh   <= {cmdSh[CMD_W-2:0], sdi};
          riseCnt <= riseCnt + CNT_W'(1);
        end
        if (lenLoad) lenCode <= {cmdSh[0], sdi};
        if (fallStb && fallCnt < activeLen) fallCnt <= fallCnt + CNT_W'(1);
        if (lastFall && cmdCode != RSV_CODE) begin
          lsbPend  <= cmdSh[1];
          fmtPend  <= cmdSh[0];
          doneFlag <= 1'b1;
          if (cmdCode == PD_CODE) begin
            powerDown <= 1'b1;
          end else begin
            powerDown <= 1'b0;
            convStart <= 1'b1;
            convChan  <= cmdCode;
          end
        end
      end
    end
  end

  always_comb begin
    ctl.fallStb  = fallStb;
    ctl.lenLoad  = lenLoad;
    ctl.bitIdx   = fallCnt;
    ctl.lenCode  = lenCode;
    ctl.lsbFirst = lsbFirst;
    ctl.outEn    = outEn;
    ctl.fmtBit   = fmtPend;
  end

  // trigger count within the current frame
  logic [1:0] trigSeen;
  always_ff @(posedge clk) begin
    if (!rstN || csN) trigSeen <= '0;
    else if (convStart && trigSeen != 2'd3) trigSeen <= trigSeen + 2'd1;
  end

  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);
  p_one_trig_frame_r4: assert property (@(posedge clk) disable iff (!rstN)
    trigSeen <= 2'd1);
  p_order_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    !csN |=> $stable(lsbFirst));
endmodule

// File: rtl/spd_data.sv
module spd_data
  import adc_port_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  portCtlT          ctl,
  input  logic [RES_W-1:0] resultIn,
  input  logic             resultValid,
  output logic             sdo
);
  logic [RES_W-1:0]    resBuf;
  logic [LEN_LONG-1:0] word;
  logic [CNT_W-1:0]    len;
  logic [IDX_W-1:0]    pos;

  always_ff @(posedge clk) begin
    if (!rstN) resBuf <= '0;
    else if (resultValid)
      resBuf <= {resultIn[RES_W-1] ^ ctl.fmtBit, resultIn[RES_W-2:0]};
  end

  always_comb begin
    len = lenOf(ctl.lenCode);
    case (ctl.lenCode)
      2'b11:   word = {resBuf, {PAD_W{1'b0}}};
      2'b01:   word = {{(2*PAD_W){1'b0}}, resBuf[RES_W-1:PAD_W]};
      default: word = {{PAD_W{1'b0}}, resBuf};
    endcase
    pos = ctl.lsbFirst ? ctl.bitIdx[IDX_W-1:0]
                       : IDX_W'(len - CNT_W'(1) - ctl.bitIdx);
    sdo = ctl.outEn && (ctl.bitIdx < len) && word[pos];
  end

  p_idle_cleared_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.outEn |-> (ctl.bitIdx == '0));
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdoEn,
  input  logic [RES_W-1:0]  resultIn,
  input  logic              resultValid,
  output logic              convStart,
  output logic [CODE_W-1:0] convChan,
  output logic              powerDown
);
  portCtlT ctl;

  spd_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .ctl(ctl),
    .convStart(convStart), .convChan(convChan), .powerDown(powerDown)
  );

  spd_data i_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .resultIn(resultIn),
    .resultValid(resultValid), .sdo(sdo)
  );

  assign sdoEn = ctl.outEn;

  p_sdo_on_fall_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && ctl.outEn && !ctl.fallStb && !ctl.lenLoad && !resultValid)
      |=> $stable(sdo));
endmodule

// File: tb/test_adc_serial_port.sv
`timescale 1ns/1ps
module test_adc_serial_port;
  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [11:0] resultIn = '0;
  logic resultValid = 1'b0;
  logic sdo, sdoEn, convStart, powerDown;
  logic [3:0] convChan;

  int checks = 0, failures = 0;
  int trigCnt = 0, trigFall = -1, trigChan = -1, fallsSoFar = 0;
  int mLen = 12, mBufV = 0;
  bit mLsb = 0, mPd = 0;

  always #2.5 clk = ~clk;

  adc_serial_port i_adc_serial_port (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .sdoEn(sdoEn), .resultIn(resultIn), .resultValid(resultValid),
    .convStart(convStart), .convChan(convChan), .powerDown(powerDown)
  );

  always @(negedge clk) if (convStart) begin
    trigCnt++; trigFall = fallsSoFar; trigChan = convChan;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lenOfB(input bit [1:0] c);
    return (c == 2'b11) ? 16 : (c == 2'b01) ? 8 : 12;
  endfunction

  function automatic int expBit(input int v, input int l, input bit lsb, input int k);
    int w = (l == 16) ? (v << 4) : (l == 8) ? (v >> 4) : v;
    int p = lsb ? k : l - 1 - k;
    return (w >> p) & 1;
  endfunction

  task automatic frame(input logic [7:0] cmd, input int nClk, input int res);
    int  code     = int'(cmd[7:4]);
    bit  rsv      = (code == 15);
    int  oldLen   = mLen;
    int  effLen   = (rsv || nClk < 6) ? oldLen : lenOfB(cmd[3:2]);
    bit  skip     = mLsb && (effLen != oldLen);
    bit  complete = (nClk >= effLen);
    bit  expTrig  = complete && (code <= 13);
    int  t0       = trigCnt;
    @(negedge clk); csN = 1'b0; fallsSoFar = 0;
    repeat (2) @(negedge clk);
    chk(sdoEn == 1'b1, "R9 enable in frame", int'(sdoEn), 1);
    for (int k = 0; k < nClk; k++) begin
      if (k >= effLen)
        chk(sdo == 1'b0, "R4 sdo beyond length", int'(sdo), 0);
      else if (!skip)
        chk(int'(sdo) == expBit(mBufV, effLen, mLsb, k), "R3/R5/R6 output bit",
            int'(sdo), expBit(mBufV, effLen, mLsb, k));
      sdi = (k < 8) ? cmd[7-k] : 1'b0;
      sclk = 1'b1; repeat (2) @(negedge clk);
      sclk = 1'b0; fallsSoFar = k + 1; repeat (2) @(negedge clk);
    end
    chk(trigCnt - t0 == (expTrig ? 1 : 0), "R1/R7/R8/R9 trigger count",
        trigCnt - t0, expTrig ? 1 : 0);
    if (expTrig) begin
      chk(trigFall == effLen, "R2 trigger edge", trigFall, effLen);
      chk(trigChan == code, "R1 channel", trigChan, code);
    end
    if (complete && !rsv) mPd = (code == 14);
    chk(powerDown == mPd, "R7/R8 power-down flag", int'(powerDown), int'(mPd));
    csN = 1'b1; sdi = 1'b0;
    repeat (2) @(negedge clk);
    chk(sdoEn == 1'b0, "R9 idle enable", int'(sdoEn), 0);
    mLen = effLen;
    if (complete && !rsv) mLsb = cmd[1];
    if (expTrig) begin
      resultIn = res[11:0]; resultValid = 1'b1;
      @(negedge clk); resultValid = 1'b0;
      mBufV = res ^ (cmd[0] ? 'h800 : 0);
    end
  endtask

  initial begin
    #1000000;
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(sdoEn == 1'b0, "R10 reset enable", int'(sdoEn), 0);
    chk(convStart == 1'b0, "R10 reset trigger", int'(convStart), 0);
    chk(powerDown == 1'b0, "R10 reset power-down", int'(powerDown), 0);
    frame(8'h30, 12, 'hA5C);   // R10 default 12-bit MSB, zero result
    frame(8'h5C, 16, 'h3F1);   // R3 16-bit pad
    frame(8'hA4, 8,  'h000);   // R3 8-bit truncate
    frame(8'h29, 12, 'h800);   // R2 code 10, R6 bipolar
    frame(8'h12, 12, 'h123);   // R5 order change waits
    frame(8'h12, 12, 'h456);   // R5 LSB first
    frame(8'h1E, 16, 'h789);   // R5 length change, LSB first
    frame(8'h1E, 16, 'hABC);   // R5 clean afterwards
    frame(8'hE0, 12, 'h000);   // R7 power-down
    frame(8'hF5, 12, 'h000);   // R8 reserved ignored
    frame(8'hD0, 15, 'h001);   // R4 extra clocks, R7 cleared
    frame(8'h46, 5,  'h000);   // R9 aborted frame
    frame(8'h30, 12, 'h000);   // R9 nothing committed
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule